// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming frame is meant for this station by looking only at the frame's 48-bit destination address. The address arrives in parallel with a one-cycle strobe. Three mode inputs, promiscuous, all-multicast and broadcast-accept, control the decision. So does a table of 16 station addresses, each with its own bit in an enable mask. The block returns an accept decision and a 16-bit packet-type word, which the receive path merges into the frame's status word.

The checks follow a fixed priority, and the first one that hits decides the result:

1. Promiscuous mode accepts any individual address, meaning one whose group bit is clear. It sets no type flag.
2. All-multicast mode accepts any group address and sets the multicast flag.
3. Broadcast-accept mode accepts the all-ones address and sets the broadcast flag.
4. The address table accepts an exact match against any enabled entry. It sets no type flag.

A frame that hits none of these is rejected. The first byte of the address on the wire sits in bits 7:0 of the address input, and its bit 0 is the group bit. Table entry *e* occupies bits 48e+47 down to 48e of the table input, and it uses the same byte layout as the address.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is held and after it is released, res_valid, res_accept and res_type are all 0 until the first address strobe.
- R2: res_valid goes high exactly one clock after a cycle with dst_valid high, and it stays high for exactly one cycle per strobe. The matching accept and type are presented in that same cycle.
- R3: When promiscuous mode is on and bit 0 of the address is 0, the frame is accepted with res_type = 0. This holds whatever the other modes and the table contain.
- R4: When promiscuous mode is on and bit 0 of the address is 1, promiscuous mode decides nothing, and the later checks decide the result.
- R5: When all-multicast mode is on, bit 0 of the address is 1 and R3 does not apply, the frame is accepted with res_type bit 8 set and every other bit clear.
- R6: When broadcast-accept mode is on, the address is all ones and neither R3 nor R5 applies, the frame is accepted with res_type bit 7 set and every other bit clear. When all-multicast mode is also on, R5 wins.
- R7: When no earlier check hits and the address equals an enabled table entry in all 48 bits, the frame is accepted with res_type = 0. This holds for every entry index, including 0 and 15.
- R8: An entry whose enable bit is 0 never matches, even when it equals the address. With an all-zero mask and all modes off, every frame is rejected.
- R9: When no check hits, res_accept is 0 and res_type is 0.
- R10: res_accept and res_type change only in the cycle after a strobe. Between strobes they hold their last value while the address, the modes, the table or the mask change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dst_valid | input | 1 | One-cycle strobe qualifying dst_addr |
| dst_addr | input | 48 | Destination address; first byte in bits 7:0, group bit at bit 0 |
| cfg_promisc | input | 1 | Promiscuous mode (individual addresses accepted) |
| cfg_all_mcast | input | 1 | All-multicast mode |
| cfg_bcast_ok | input | 1 | Broadcast-accept mode |
| tbl_entries | input | 768 | 16 table entries of 48 bits, entry e at bits 48e+47:48e |
| tbl_enable | input | 16 | Per-entry enable mask |
| res_valid | output | 1 | Result strobe, one clock after dst_valid |
| res_accept | output | 1 | Frame accepted |
| res_type | output | 16 | Packet type: bit 8 multicast, bit 7 broadcast, others 0 |

## Verification
Every result is due in the single clock cycle after its strobe, because the comparators, the priority logic and one register are the only stages on the path. The bench drives each strobe on a falling edge and holds it for one full cycle. It reads the result at the next falling edge, which is half a cycle after the rising edge that registers it. The latency checks also sample the strobe cycle itself, where res_valid must still be low, and the cycle after the result, where res_valid must have dropped. The hold checks sample over three strobe-free cycles while the other inputs change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned TYPE_W      = 16;
  localparam int unsigned TYPE_MC_BIT = 8;
  localparam int unsigned TYPE_BC_BIT = 7;
  localparam int unsigned GROUP_BIT   = 0;

  typedef struct packed {
    logic       accept;
    logic [TYPE_W-1:0] ptype;
  } rxf_result_t;
endpackage

// File: rtl/rxf_addr_class.sv
module rxf_addr_class #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_group,
  output logic              is_bcast
);
  logic [ADDR_BYTES-1:0] byte_ones;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign byte_ones[b] = &addr[8*b +: 8];
  end

  assign is_group = addr[rxf_pkg::GROUP_BIT];
  assign is_bcast = &byte_ones;
endmodule

// File: rtl/rxf_table_match.sv
module rxf_table_match #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned ENTRIES    = 16,
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ENTRIES*ADDR_W-1:0] entries,
  input  logic [ENTRIES-1:0]        enable,
  output logic                      any_hit
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign hit_vec[e] = enable[e] && (entries[e*ADDR_W +: ADDR_W] == addr);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/rxf_priority.sv
module rxf_priority
  import rxf_pkg::*;
(
  input  logic        promisc,
  input  logic        all_mcast,
  input  logic        bcast_ok,
  input  logic        is_group,
  input  logic        is_bcast,
  input  logic        table_hit,
  output rxf_result_t result
);
  always_comb begin
    result = '0;
    if (promisc && !is_group) begin
      result.accept = 1'b1;
    end else if (all_mcast && is_group) begin
      result.accept = 1'b1;
      result.ptype[TYPE_MC_BIT] = 1'b1;
    end else if (bcast_ok && is_bcast) begin
      result.accept = 1'b1;
      result.ptype[TYPE_BC_BIT] = 1'b1;
    end else if (table_hit) begin
      result.accept = 1'b1;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned ENTRIES    = 16,
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dst_valid,
  input  logic [ADDR_W-1:0]         dst_addr,
  input  logic                      cfg_promisc,
  input  logic                      cfg_all_mcast,
  input  logic                      cfg_bcast_ok,
  input  logic [ENTRIES*ADDR_W-1:0] tbl_entries,
  input  logic [ENTRIES-1:0]        tbl_enable,
  output logic                      res_valid,
  output logic                      res_accept,
  output logic [TYPE_W-1:0]         res_type
);
  logic        grp_w;
  logic        bc_w;
  logic        hit_w;
  rxf_result_t next_res;

  rxf_addr_class #(.ADDR_BYTES(ADDR_BYTES)) u_class (
    .addr     (dst_addr),
    .is_group (grp_w),
    .is_bcast (bc_w)
  );

  rxf_table_match #(.ADDR_BYTES(ADDR_BYTES), .ENTRIES(ENTRIES)) u_match (
    .addr    (dst_addr),
    .entries (tbl_entries),
    .enable  (tbl_enable),
    .any_hit (hit_w)
  );

  rxf_priority u_prio (
    .promisc   (cfg_promisc),
    .all_mcast (cfg_all_mcast),
    .bcast_ok  (cfg_bcast_ok),
    .is_group  (grp_w),
    .is_bcast  (bc_w),
    .table_hit (hit_w),
    .result    (next_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_type   <= '0;
    end else begin
      res_valid <= dst_valid;
      if (dst_valid) begin
        res_accept <= next_res.accept;
        res_type   <= next_res.ptype;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned ENTRIES    = 16,
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      dst_valid,
  input logic [ADDR_W-1:0]         dst_addr,
  input logic                      cfg_promisc,
  input logic                      cfg_all_mcast,
  input logic                      cfg_bcast_ok,
  input logic [ENTRIES-1:0]        tbl_enable,
  input logic                      res_valid,
  input logic                      res_accept,
  input logic [TYPE_W-1:0]         res_type
);
  localparam logic [TYPE_W-1:0] FLAG_MASK =
    (TYPE_W'(1) << TYPE_MC_BIT) | (TYPE_W'(1) << TYPE_BC_BIT);

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    dst_valid |=> res_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !dst_valid |=> !res_valid); // R2
  AST_PROMISC_UNICAST: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && cfg_promisc && !dst_addr[GROUP_BIT]) |=> (res_accept && res_type == '0)); // R3
  AST_ALLMC_GROUP: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && cfg_all_mcast && dst_addr[GROUP_BIT]) |=> (res_accept && res_type[TYPE_MC_BIT])); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones(res_type & FLAG_MASK) <= 1 && (res_type & ~FLAG_MASK) == '0); // R6
  AST_EMPTY_MASK_REJECT: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && tbl_enable == '0 && !cfg_promisc && !cfg_all_mcast && !cfg_bcast_ok)
      |=> !res_accept); // R8
  AST_REJECT_NO_TYPE: assert property (@(posedge clk) disable iff (rst)
    !res_accept |-> res_type == '0); // R9
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !dst_valid |=> ($stable(res_accept) && $stable(res_type))); // R10
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.ADDR_BYTES(ADDR_BYTES), .ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dst_valid     (dst_valid),
  .dst_addr      (dst_addr),
  .cfg_promisc   (cfg_promisc),
  .cfg_all_mcast (cfg_all_mcast),
  .cfg_bcast_ok  (cfg_bcast_ok),
  .tbl_enable    (tbl_enable),
  .res_valid     (res_valid),
  .res_accept    (res_accept),
  .res_type      (res_type)
);

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
  localparam int ENT = 16;
  localparam int AW  = 48;
  localparam logic [15:0] T_MC = 16'h0100;
  localparam logic [15:0] T_BC = 16'h0080;
  localparam logic [47:0] A_UNI  = 48'h6677_8899_AA40;
  localparam logic [47:0] A_GRP  = 48'h6677_8899_AA41;
  localparam logic [47:0] A_BC   = 48'hFFFF_FFFF_FFFF;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           dst_valid = 1'b0;
  logic [AW-1:0]  dst_addr = '0;
  logic           cfg_promisc = 1'b0;
  logic           cfg_all_mcast = 1'b0;
  logic           cfg_bcast_ok = 1'b0;
  logic [ENT*AW-1:0] tbl_entries = '0;
  logic [ENT-1:0] tbl_enable = '0;
  logic           res_valid;
  logic           res_accept;
  logic [15:0]    res_type;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_dest_filter i_rx_dest_filter (
    .clk(clk), .rst(rst), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast), .cfg_bcast_ok(cfg_bcast_ok),
    .tbl_entries(tbl_entries), .tbl_enable(tbl_enable),
    .res_valid(res_valid), .res_accept(res_accept), .res_type(res_type)
  );

  function automatic logic [47:0] entry_val(int e);
    if (e == 3) return 48'h5544_3322_1107;
    return {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'(e * 2)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_modes(logic p, logic m, logic b);
    cfg_promisc = p; cfg_all_mcast = m; cfg_bcast_ok = b;
  endtask

  // Strobe one address and check result at the following falling edge
  task automatic probe(string req, logic [47:0] a, logic exp_acc, logic [15:0] exp_type);
    @(negedge clk);
    dst_addr = a;
    dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    check(req, {15'd0, res_valid, res_accept, res_type}, {15'd0, 1'b1, exp_acc, exp_type});
  endtask

  task automatic t_reset;
    check("R1", {15'd0, res_valid, res_accept, res_type}, 32'd0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", {15'd0, res_valid, res_accept, res_type}, 32'd0);
  endtask

  task automatic t_latency;
    set_modes(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    dst_addr = A_UNI; dst_valid = 1'b1;
    #1 check("R2", {31'd0, res_valid}, 32'd0);
    @(negedge clk); dst_valid = 1'b0;
    check("R2", {30'd0, res_valid, res_accept}, 32'd3);
    @(negedge clk);
    check("R2", {31'd0, res_valid}, 32'd0);
    set_modes(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_promisc;
    set_modes(1'b1, 1'b0, 1'b0);
    probe("R3", A_UNI, 1'b1, 16'h0);
    set_modes(1'b1, 1'b1, 1'b1);
    probe("R3", A_UNI, 1'b1, 16'h0);
    probe("R3", entry_val(5), 1'b1, 16'h0);
  endtask

  task automatic t_promisc_group;
    set_modes(1'b1, 1'b0, 1'b0);
    probe("R4", A_GRP, 1'b0, 16'h0);
    probe("R4", entry_val(3), 1'b1, 16'h0);
    set_modes(1'b1, 1'b0, 1'b1);
    probe("R4", A_BC, 1'b1, T_BC);
    set_modes(1'b1, 1'b1, 1'b0);
    probe("R4", A_GRP, 1'b1, T_MC);
  endtask

  task automatic t_allmc;
    set_modes(1'b0, 1'b1, 1'b0);
    probe("R5", A_GRP, 1'b1, T_MC);
    probe("R5", entry_val(3), 1'b1, T_MC);
    probe("R5", A_UNI, 1'b0, 16'h0);
  endtask

  task automatic t_bcast;
    set_modes(1'b0, 1'b0, 1'b1);
    probe("R6", A_BC, 1'b1, T_BC);
    probe("R6", 48'hFFFF_FFFF_FFFE, 1'b0, 16'h0);
    set_modes(1'b0, 1'b1, 1'b1);
    probe("R6", A_BC, 1'b1, T_MC);
    set_modes(1'b0, 1'b0, 1'b0);
    probe("R6", A_BC, 1'b0, 16'h0);
  endtask

  task automatic t_table;
    set_modes(1'b0, 1'b0, 1'b0);
    probe("R7", entry_val(0), 1'b1, 16'h0);
    probe("R7", entry_val(5), 1'b1, 16'h0);
    probe("R7", entry_val(15), 1'b1, 16'h0);
    probe("R7", entry_val(5) ^ 48'h0100_0000_0000, 1'b0, 16'h0);
  endtask

  task automatic t_disabled;
    set_modes(1'b0, 1'b0, 1'b0);
    tbl_enable = 16'hFFDF;
    probe("R8", entry_val(5), 1'b0, 16'h0);
    probe("R8", entry_val(6), 1'b1, 16'h0);
    tbl_enable = 16'h0000;
    probe("R8", entry_val(0), 1'b0, 16'h0);
    probe("R8", entry_val(15), 1'b0, 16'h0);
    tbl_enable = 16'hFFFF;
  endtask

  task automatic t_reject;
    set_modes(1'b0, 1'b0, 1'b0);
    probe("R7", entry_val(9), 1'b1, 16'h0);
    probe("R9", A_GRP, 1'b0, 16'h0);
    set_modes(1'b0, 1'b1, 1'b0);
    probe("R5", A_GRP, 1'b1, T_MC);
    probe("R9", A_UNI, 1'b0, 16'h0);
  endtask

  task automatic t_hold;
    set_modes(1'b0, 1'b1, 1'b0);
    probe("R10", A_GRP, 1'b1, T_MC);
    for (int k = 0; k < 3; k++) begin
      dst_addr = A_UNI ^ 48'(k);
      set_modes(1'b0, 1'b0, 1'b0);
      tbl_enable = '0;
      @(negedge clk);
      check("R10", {15'd0, res_valid, res_accept, res_type}, {15'd0, 1'b0, 1'b1, T_MC});
    end
    tbl_enable = 16'hFFFF;
  endtask

  initial begin
    for (int e = 0; e < ENT; e++) tbl_entries[e*AW +: AW] = entry_val(e);
    tbl_enable = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_promisc();
    t_promisc_group();
    t_allmc();
    t_bcast();
    t_table();
    t_disabled();
    t_reject();
    t_hold();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule